// File: doc/BRIEF.md
# Central Round-Robin Bus Arbiter

This block decides which of several bus masters may drive a shared bus next. Each master has a private request input and a private grant output; no line is shared between masters. The arbiter runs on the bus clock and watches a single bus-busy input that tells it whether the current owner is still in the middle of a transfer.

The choice of the next owner is made continuously, in parallel with the transfer in progress. The grant is frozen while the bus is busy, and it is handed to the chosen requester at the first clock edge that sees the bus idle. That master sees its grant in the next cycle and may start at once, so no bus cycle is spent on arbitration. Requesters are served in circular order starting just after the most recent owner. With nothing requested, the grant stays parked on the last owner so it can start again without waiting.

A master that has just received a grant keeps it until it has actually used the bus (driven busy at least once while granted), so a fresh grant is never taken away before its owner can start.

Top module: `bus_arbiter`

## Requirements
- R1: During and after reset no grant is asserted, and the circular search starts so that master 0 is the first candidate.
- R2: At most one bit of the grant vector is high in any cycle.
- R3: When no grant is active and at least one request is high at a clock edge, the grant goes at that edge to the first requesting master after the most recent owner in circular order (index ascending, wrapping from NUM_MASTERS-1 to 0).
- R4: While bus-busy is high, the grant vector does not change.
- R5: At an edge where the bus is idle, the owner has already driven busy during its grant and another master requests, the grant moves at that edge to the first other requester after the owner in circular order, wrapping past the highest index.
- R6: A granted master that keeps requesting and has not yet driven busy keeps its grant, even when other masters request.
- R7: If the owner's request is low while the bus is idle and another master requests, the owner's grant is removed at the next edge and given to that requester.
- R8: With no request pending, the grant stays parked on the current owner.
- R9: An owner that is the only requester keeps its grant across back-to-back transfers.
- R10: A grant is never newly given to a master whose request was low at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_MASTERS | Request line per master, bit i is master i |
| busy_i | input | 1 | High while a transfer is in progress on the bus |
| gnt_o | output | NUM_MASTERS | Registered grant line per master, bit i is master i |

## Verification
Every grant decision is taken from the inputs present at one rising edge and appears on the grant outputs right after that edge, so each result is due exactly one clock after the stimulus that causes it. The bench changes inputs at falling edges and reads the grants at the next falling edge, one rising edge later, so each check sees the result of exactly one decision. Hold cases (busy bus, unused grant, parking, sole requester) are checked over several consecutive cycles to show the grant does not drift.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Outcome of one arbitration decision.
  typedef enum logic [1:0] {
    DEC_HOLD     = 2'd0,  // keep the current grant vector
    DEC_FIRST    = 2'd1,  // no grant active: give the bus to the winner
    DEC_HANDOVER = 2'd2   // bus idle: pass the bus to the winner
  } arb_dec_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Circular search: offsets 1..NUM from the base index; the smallest
// offset with a request wins. Offset NUM is the base itself.
module arb_rr_pick #(
  parameter int NUM   = 4,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0]   req,
  input  logic [IDX_W-1:0] base,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  localparam int SUM_W = IDX_W + 1;

  logic [SUM_W-1:0] pos [NUM];

  // Wrapped position for each offset.
  for (genvar k = 0; k < NUM; k++) begin : g_pos
    logic [SUM_W-1:0] raw;
    assign raw    = {1'b0, base} + SUM_W'(k + 1);
    assign pos[k] = (raw >= SUM_W'(NUM)) ? raw - SUM_W'(NUM) : raw;
  end

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (req[pos[k][IDX_W-1:0]]) begin
        valid = 1'b1;
        idx   = pos[k][IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/arb_decide.sv
// Combinational decision: which requests are eligible and whether the
// grant may change at the coming edge.
module arb_decide
  import arb_pkg::*;
#(
  parameter int NUM = 4
) (
  input  logic [NUM-1:0] req,
  input  logic [NUM-1:0] gnt_q,
  input  logic           busy,
  input  logic           used_q,
  input  logic           pick_valid,
  output logic [NUM-1:0] eligible,
  output arb_dec_e       dec
);

  logic gnt_act;
  logic owner_req;

  assign gnt_act   = |gnt_q;
  assign owner_req = |(req & gnt_q);
  // With an owner, only the other masters compete.
  assign eligible  = gnt_act ? (req & ~gnt_q) : req;

  always_comb begin
    dec = DEC_HOLD;
    if (!gnt_act) begin
      if (pick_valid) dec = DEC_FIRST;
    end else if (!busy && pick_valid && (!owner_req || used_q)) begin
      dec = DEC_HANDOVER;
    end
  end

endmodule

// File: rtl/arb_state.sv
// Grant, last-owner pointer and used flag registers.
module arb_state
  import arb_pkg::*;
#(
  parameter int NUM   = 4,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  arb_dec_e         dec,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             busy,
  output logic [NUM-1:0]   gnt_q,
  output logic [IDX_W-1:0] last_q,
  output logic             used_q
);

  logic [NUM-1:0] win_onehot;

  for (genvar i = 0; i < NUM; i++) begin : g_oh
    assign win_onehot[i] = (win_idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      last_q <= IDX_W'(NUM - 1);
      used_q <= 1'b0;
    end else begin
      case (dec)
        DEC_FIRST, DEC_HANDOVER: begin
          gnt_q  <= win_onehot;
          last_q <= win_idx;
          used_q <= 1'b0;
        end
        default: begin
          used_q <= used_q | ((|gnt_q) & busy);
        end
      endcase
    end
  end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   busy_i,
  output logic [NUM_MASTERS-1:0] gnt_o
);

  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [NUM_MASTERS-1:0] gnt_q;
  logic [NUM_MASTERS-1:0] eligible;
  logic [IDX_W-1:0]       last_q;
  logic [IDX_W-1:0]       win_idx;
  logic                   win_valid;
  logic                   used_q;
  arb_dec_e               dec;

  arb_rr_pick #(.NUM(NUM_MASTERS)) u_pick (
    .req   (eligible),
    .base  (last_q),
    .valid (win_valid),
    .idx   (win_idx)
  );

  arb_decide #(.NUM(NUM_MASTERS)) u_decide (
    .req        (req_i),
    .gnt_q      (gnt_q),
    .busy       (busy_i),
    .used_q     (used_q),
    .pick_valid (win_valid),
    .eligible   (eligible),
    .dec        (dec)
  );

  arb_state #(.NUM(NUM_MASTERS)) u_state (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .win_idx (win_idx),
    .busy    (busy_i),
    .gnt_q   (gnt_q),
    .last_q  (last_q),
    .used_q  (used_q)
  );

  assign gnt_o = gnt_q;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NUM-1:0] req_i,
  input logic           busy_i,
  input logic [NUM-1:0] gnt_o
);

  // R1: grant clear after a reset edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (gnt_o == '0));

  // R2: at most one grant
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  // R3: free bus with requests gets an owner at the next edge
  assert_first_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0));

  // R4: grant frozen while busy
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_i && gnt_o != '0) |=> $stable(gnt_o));

  // R7: idle bus, owner not requesting, others requesting -> grant moves
  assert_drop_moves_R7: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && !busy_i && (req_i & gnt_o) == '0 && (req_i & ~gnt_o) != '0)
      |=> (gnt_o != $past(gnt_o)));

  // R8: parked grant with no requests
  assert_park_R8: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && req_i == '0) |=> $stable(gnt_o));

  for (genvar i = 0; i < NUM; i++) begin : g_bit
    // R10: new grants only to requesters
    assert_grant_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(gnt_o[i]) |-> $past(req_i[i]));
  end

endmodule

bind bus_arbiter arb_checker #(.NUM(NUM_MASTERS)) u_arb_checker (
  .clk    (clk),
  .rst    (rst),
  .req_i  (req_i),
  .busy_i (busy_i),
  .gnt_o  (gnt_o)
);

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic         busy_i = 1'b0;
  logic [N-1:0] gnt_o;

  int checks = 0;
  int errors = 0;

  bus_arbiter #(.NUM_MASTERS(N)) dut (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .busy_i (busy_i),
    .gnt_o  (gnt_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [N-1:0] exp);
    checks++;
    if (gnt_o !== exp) begin
      errors++;
      $display("FAIL %s gnt actual=%b expected=%b", tag, gnt_o, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; req_i = '0; busy_i = 1'b0;
    repeat (3) tick();
    check("R1 in reset", 4'b0000);
    rst = 1'b0;
    tick();
    check("R1 after reset, no requests", 4'b0000);
  endtask

  task automatic t_first_grant();
    req_i = 4'b1010;
    tick();
    check("R3 first grant to master 1", 4'b0010);
  endtask

  task automatic t_unused_hold();
    repeat (2) begin
      tick();
      check("R6 unused grant kept", 4'b0010);
    end
  endtask

  task automatic t_busy_then_handover();
    busy_i = 1'b1;
    req_i  = 4'b1100;
    repeat (3) begin
      tick();
      check("R4 grant frozen while busy", 4'b0010);
    end
    busy_i = 1'b0;
    tick();
    check("R5 handover to master 2 on idle", 4'b0100);
  endtask

  task automatic t_drop_while_idle();
    tick();
    check("R6 fresh owner 2 kept", 4'b0100);
    req_i = 4'b1000;
    tick();
    check("R7 owner dropped, moves to 3", 4'b1000);
  endtask

  task automatic t_park();
    req_i = 4'b0000;
    repeat (3) begin
      tick();
      check("R8 parked on master 3", 4'b1000);
    end
  endtask

  task automatic t_sole_owner();
    req_i = 4'b1000;
    for (int r = 0; r < 2; r++) begin
      busy_i = 1'b1;
      repeat (2) begin
        tick();
        check("R9 sole owner busy", 4'b1000);
      end
      busy_i = 1'b0;
      tick();
      check("R9 sole owner idle", 4'b1000);
    end
  endtask

  task automatic t_wrap();
    req_i = 4'b0011;
    tick();
    check("R5 wrap from 3 to 0", 4'b0001);
  endtask

  task automatic t_skip_idle_master();
    tick();
    check("R6 owner 0 kept before use", 4'b0001);
    busy_i = 1'b1;
    tick();
    check("R4 owner 0 busy", 4'b0001);
    busy_i = 1'b0;
    req_i  = 4'b0101;
    tick();
    check("R10 master 1 not requesting, skip to 2", 4'b0100);
  endtask

  task automatic t_reset_mid_run();
    rst = 1'b1;
    tick();
    check("R1 reset clears grant", 4'b0000);
    rst   = 1'b0;
    req_i = 4'b1000;
    tick();
    check("R3 after reset only master 3 requests", 4'b1000);
    rst   = 1'b1;
    tick();
    rst   = 1'b0;
    req_i = 4'b1001;
    tick();
    check("R1 master 0 first after reset", 4'b0001);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_grant();
    t_unused_hold();
    t_busy_then_handover();
    t_drop_while_idle();
    t_park();
    t_sole_owner();
    t_wrap();
    t_skip_idle_master();
    t_reset_mid_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule